// File: doc/BRIEF.md
# Multi-format serial audio receiver

This block receives stereo serial audio as a slave. An external host drives the bit clock, the frame (left/right) clock and the serial data line. All three are synchronous to a faster system clock, and the block samples them in that clock's domain. For each frame the block deserialises one left word and one right word. Three framing styles are supported: I2S (one-bit delay), MSB-justified and LSB-justified. The sample length can be 16, 18 or 20 bits. Both words are delivered as 20-bit two's-complement values with a single-cycle valid strobe.

Format and sample length are static inputs, and a change to them should be followed by a reset. The receiver watches how many bits lie between frame-clock transitions. It only declares lock, and only releases samples, once that count has been stable for two full frames. Any irregular transition mutes it again at once.

Top module: `serial_audio_rx`

## Requirements
- R1: The frame clock and serial data are sampled only at rising bit-clock edges, and data is taken MSB first.
- R2: With `fmt_sel` = 00 (I2S), the MSB arrives on the second rising bit-clock edge after a frame-clock transition. In every format, frame clock low carries the left word and high carries the right word.
- R3: With `fmt_sel` = 01 (MSB-justified), the MSB is the bit sampled on the first rising edge at which the new frame-clock level is seen. Bits after the word are ignored.
- R4: With `fmt_sel` = 1x (LSB-justified, 10 and 11 alike), the LSB is the last bit before the next frame-clock transition. Leading bits before the word are ignored.
- R5: `wlen_sel` 00/01/10 selects 16/18/20 bits, and 11 is treated as 20 bits. Shorter words are placed in the top bits of the 20-bit outputs with zeros below, so the sign is kept.
- R6: `valid_o` pulses for one system clock per frame once the right word is complete. At that moment `left_o` and `right_o` hold the left and right words of the same frame.
- R7: `locked_o` rises at the fourth consecutive frame-clock transition whose preceding half-frame had the same bit count as the half before it, and that count was at least the word length.
- R8: While `locked_o` is low, `valid_o` stays low and both sample outputs are zero.
- R9: A frame-clock transition after a half-frame of a different length, or a half-frame reaching 127 bits, drops `locked_o` and zeros the outputs in the same cycle. A right word that completes at that same transition is discarded.
- R10: After reset `valid_o` and `locked_o` are low and both sample outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bclk_i | input | 1 | Host bit clock |
| lrck_i | input | 1 | Host frame clock, low = left |
| sdata_i | input | 1 | Serial audio data |
| fmt_sel | input | 2 | Framing: 00 I2S, 01 MSB-justified, 1x LSB-justified |
| wlen_sel | input | 2 | Word length: 00 16, 01 18, 10/11 20 bits |
| left_o | output | 20 | Left sample, left-aligned two's complement |
| right_o | output | 20 | Right sample, left-aligned two's complement |
| valid_o | output | 1 | One-cycle strobe per received frame |
| locked_o | output | 1 | Framing lock indicator |

## Verification
In LSB-justified framing, the right word is only complete at the frame-clock transition that also ends its half-frame. The length check for lock therefore happens in the same cycle as the right-word capture. The bench provokes this by shortening a right half-frame while locked. It then verifies that the strobe count does not grow across the following transition, that lock is gone and that the outputs read zero. A stream of well-formed frames afterwards must bring back lock and the correct sample pair.

// File: rtl/serial_audio_rx.sv
module serial_audio_rx #(
  parameter int DW         = 20,
  parameter int CW         = 7,
  parameter int LOCK_EDGES = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bclk_i,
  input  logic          lrck_i,
  input  logic          sdata_i,
  input  logic [1:0]    fmt_sel,
  input  logic [1:0]    wlen_sel,
  output logic [DW-1:0] left_o,
  output logic [DW-1:0] right_o,
  output logic          valid_o,
  output logic          locked_o
);
  localparam int SW = $clog2(LOCK_EDGES);
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};
  localparam logic [CW-1:0] CDW  = CW'(DW);

  logic [2:0]    bclk_q;
  logic [1:0]    lr_q, sd_q;
  logic          lr_d, half_lr;
  logic [DW-1:0] shreg, left_hold;
  logic [CW-1:0] cnt, prev_len;
  logic [SW-1:0] streak;
  logic [CW-1:0] wbits;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bclk_q <= '0; lr_q <= '0; sd_q <= '0;
    end else begin
      bclk_q <= {bclk_q[1:0], bclk_i};
      lr_q   <= {lr_q[0], lrck_i};
      sd_q   <= {sd_q[0], sdata_i};
    end
  end

  wire bit_tick = bclk_q[1] & ~bclk_q[2];
  wire fmt_i2s  = (fmt_sel == 2'b00);
  wire fmt_lsb  = fmt_sel[1];
  wire lr_eff   = fmt_i2s ? lr_d : lr_q[1];
  wire edge_now = bit_tick & (lr_eff != half_lr);

  always_comb begin
    case (wlen_sel)
      2'b00:   wbits = CW'(16);
      2'b01:   wbits = CW'(18);
      default: wbits = CW'(20);
    endcase
  end

  wire len_ok   = (cnt == prev_len) && (cnt >= wbits) && (cnt != CMAX);
  wire drop     = bit_tick & (edge_now ? !len_ok : (cnt == CMAX));
  wire snap     = fmt_lsb ? edge_now : (bit_tick & (cnt == wbits));
  wire [DW-1:0] snap_word = shreg << (CDW - wbits);
  wire take_pair = snap & half_lr & locked_o & !drop;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lr_d <= 1'b0; half_lr <= 1'b0; shreg <= '0; cnt <= '0;
    end else if (bit_tick) begin
      lr_d  <= lr_q[1];
      shreg <= {shreg[DW-2:0], sd_q[1]};
      if (edge_now) begin
        half_lr <= lr_eff;
        cnt     <= CW'(1);
      end else if (cnt != CMAX) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_len <= '0; streak <= '0; locked_o <= 1'b0;
    end else if (drop) begin
      streak <= '0; locked_o <= 1'b0;
      if (edge_now) prev_len <= cnt;
    end else if (edge_now) begin
      prev_len <= cnt;
      if (streak == SW'(LOCK_EDGES - 1)) locked_o <= 1'b1;
      else streak <= streak + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      left_hold <= '0; left_o <= '0; right_o <= '0; valid_o <= 1'b0;
    end else begin
      if (snap && !half_lr) left_hold <= snap_word;
      valid_o <= take_pair;
      if (take_pair) begin
        left_o <= left_hold; right_o <= snap_word;
      end else if (drop || !locked_o) begin
        left_o <= '0; right_o <= '0;
      end
    end
  end

  p_valid_needs_lock_r8: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> locked_o);
  p_mute_when_unlocked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !locked_o |-> (left_o == '0 && right_o == '0));
  p_single_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);
  p_lock_moves_on_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(locked_o) |-> $past(bit_tick));
  p_pad_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && $past(wlen_sel) == 2'b00) |-> (left_o[3:0] == 4'd0 && right_o[3:0] == 4'd0));
endmodule

// File: tb/test_serial_audio_rx.sv
module test_serial_audio_rx;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bclk = 1'b1, lrck = 1'b0, sdata = 1'b0;
  logic [1:0] fmt_sel = 2'b01, wlen_sel = 2'b10;
  logic [19:0] left_o, right_o;
  logic valid_o, locked_o;
  int checks = 0, fails = 0, vcount = 0;
  logic [19:0] last_l = '0, last_r = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_audio_rx i_serial_audio_rx (
    .clk(clk), .rst_n(rst_n), .bclk_i(bclk), .lrck_i(lrck), .sdata_i(sdata),
    .fmt_sel(fmt_sel), .wlen_sel(wlen_sel), .left_o(left_o), .right_o(right_o),
    .valid_o(valid_o), .locked_o(locked_o));

  always @(negedge clk) if (valid_o) begin
    vcount++; last_l = left_o; last_r = right_o;
  end

  task automatic check(input string req, input logic [39:0] act, exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int wl();
    return (wlen_sel == 2'b00) ? 16 : (wlen_sel == 2'b01) ? 18 : 20;
  endfunction

  function automatic logic [19:0] align(input logic [19:0] v);
    logic [19:0] m = (20'h1 << wl()) - 1;
    return (v & m) << (20 - wl());
  endfunction

  function automatic logic bit_at(input int half, input int i, input logic [19:0] w);
    int n = wl();
    if (fmt_sel == 2'b00) return (i >= 1 && i <= n) ? w[n - i] : 1'b0;
    if (fmt_sel == 2'b01) return (i < n) ? w[n - 1 - i] : 1'b0;
    return (i >= half - n) ? w[half - 1 - i] : 1'b0;
  endfunction

  task automatic send_bit(input logic lr, input logic d);
    @(negedge clk); bclk = 1'b0; lrck = lr; sdata = d;
    repeat (4) @(negedge clk);
    bclk = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic send_frame(input int hl, input int hr, input logic [19:0] lw, input logic [19:0] rw);
    for (int i = 0; i < hl; i++) send_bit(1'b0, bit_at(hl, i, lw));
    for (int i = 0; i < hr; i++) send_bit(1'b1, bit_at(hr, i, rw));
  endtask

  task automatic restart(input logic [1:0] f, input logic [1:0] w);
    @(negedge clk); rst_n = 1'b0; fmt_sel = f; wlen_sel = w; lrck = 1'b0; bclk = 1'b1;
    repeat (4) @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic run_format(input string req, input logic [1:0] f, input logic [1:0] w,
                            input int half, input logic [19:0] lv, input logic [19:0] rv);
    int v0;
    restart(f, w);
    for (int k = 0; k < 6; k++) send_frame(half, half, lv, rv);
    repeat (6) @(negedge clk);
    check({req, " lock"}, {39'd0, locked_o}, 40'd1);
    check({req, " pair"}, {last_l, last_r}, {align(lv), align(rv)});
    v0 = vcount;
    send_frame(half, half, rv, lv);
    send_frame(half, half, rv, lv);
    repeat (6) @(negedge clk);
    check({req, " swapped pair R6"}, {last_l, last_r}, {align(rv), align(lv)});
    check({req, " one strobe per frame R6"}, 40'(vcount - v0), 40'd2);
  endtask

  task automatic test_reset();
    restart(2'b01, 2'b10);
    repeat (3) @(negedge clk);
    check("R10 reset state", {left_o[19:0], right_o[19:0]}, 40'd0);
    check("R10 reset flags", {38'd0, valid_o, locked_o}, 40'd0);
  endtask

  task automatic test_mute_before_lock();
    int v0 = vcount;
    restart(2'b01, 2'b10);
    send_frame(40, 40, 20'h12345, 20'h54321);
    repeat (6) @(negedge clk);
    check("R8 no strobe before lock", 40'(vcount - v0), 40'd0);
    check("R8 muted before lock", {locked_o, left_o, right_o[18:0]}, 40'd0);
  endtask

  task automatic test_drop_msb();
    int v0;
    restart(2'b01, 2'b10);
    for (int k = 0; k < 6; k++) send_frame(40, 40, 20'h0F0F0, 20'h70707);
    send_frame(40, 30, 20'h0F0F0, 20'h70707);
    send_frame(40, 40, 20'h0F0F0, 20'h70707);
    repeat (6) @(negedge clk);
    check("R9 lock dropped", {39'd0, locked_o}, 40'd0);
    check("R9 outputs zeroed", {left_o, right_o}, 40'd0);
    v0 = vcount;
    for (int k = 0; k < 6; k++) send_frame(40, 40, 20'h11111, 20'h22222);
    repeat (6) @(negedge clk);
    check("R7 relock", {39'd0, locked_o}, 40'd1);
    check("R7 relock pair", {last_l, last_r}, {20'h11111, 20'h22222});
    check("R7 strobes resume", 40'(vcount > v0), 40'd1);
  endtask

  task automatic test_drop_lsb_same_edge();
    int v0;
    restart(2'b10, 2'b01);
    for (int k = 0; k < 6; k++) send_frame(24, 24, 20'h2AAAA, 20'h15555);
    send_frame(24, 20, 20'h2AAAA, 20'h15555);
    repeat (6) @(negedge clk);
    v0 = vcount;
    send_frame(24, 24, 20'h2AAAA, 20'h15555);
    repeat (6) @(negedge clk);
    check("R9 right word discarded at bad edge", 40'(vcount - v0), 40'd0);
    check("R9 unlocked after short half", {39'd0, locked_o}, 40'd0);
    check("R9 zero after short half", {left_o, right_o}, 40'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    test_reset();
    test_mute_before_lock();
    run_format("R3 R1 R7 msb20", 2'b01, 2'b10, 40, 20'h9ABCD, 20'h13579);
    run_format("R2 R5 i2s16", 2'b00, 2'b00, 32, 20'h0C3A5, 20'h08001);
    run_format("R4 R5 lsb18", 2'b10, 2'b01, 24, 20'h2F00F, 20'h1234B);
    run_format("R4 fmt11 lsb16", 2'b11, 2'b00, 32, 20'h0FFFF, 20'h08000);
    run_format("R5 wlen11 as 20 i2s", 2'b00, 2'b11, 24, 20'hFEDCB, 20'h00001);
    test_drop_msb();
    test_drop_lsb_same_edge();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule